// File: doc/BRIEF.md
# Merging Write Buffer with Load Forwarding

This block sits between a write-through cache and main memory and holds stores that have not yet reached memory. Each of its entries covers one aligned block of four 8-byte words and keeps a separate valid bit for every word. A store to a block that already has an entry is written into that entry. A store to any other block opens a new entry. Entries leave for memory oldest first, one per handshake. Each transfer carries the block base address, the four data words and the mask of the words that were written.

A read lookup port lets the cache ask about a load that missed. A build-time mode chooses how that request is handled. In forward mode the buffer returns the word itself when it holds a valid copy. A store accepted in the same cycle is included in that answer. In stall mode the buffer never returns data. Instead it holds the read off with a stall signal until every pending store has left.

Top module: `wbuf_merge`

## Requirements
- R1: A store (`st_valid` high while `st_ready` is high) to a block that has no entry opens a new entry, and `count` rises by one. Address bits [4:3] select the word slot. Bits [ADDR_W-1:5] name the block. Only that slot's valid bit is set in the new entry.
- R2: A store to a block that already has an entry leaves `count` unchanged and sets the valid bit of the addressed slot. A later store to the same word replaces the earlier data.
- R3: When every entry is in use, `st_ready` is low for a store to a new block. A store to a block that is already buffered is still accepted.
- R4: While the buffer is not empty, `drain_valid` is high and the drain port shows the oldest entry. `drain_addr` is the block base with bits [4:0] zero. Bit k of `drain_mask` marks word k as valid. Word k sits in `drain_data[64k+63:64k]`. The entry leaves in the cycle where `drain_ready` is high. While `drain_ready` is low, `drain_addr` stays the same.
- R5: Entries leave in the order in which they were opened.
- R6: In forward mode, `rd_hit` is high in the same cycle as `rd_valid` exactly when the buffer holds a valid copy of the addressed word, and `rd_data` is then that word. `rd_hit` is low when the block is absent or the word's bit is clear. `rd_stall` stays low.
- R7: In forward mode, a store accepted in the same cycle as a lookup of the same word makes the lookup hit, with the store's data.
- R8: In stall mode, `rd_hit` is never high. `rd_stall` is high while `rd_valid` is high and either the buffer holds an entry or a store is accepted in that cycle.
- R9: A store to the oldest entry's block, made in the cycle where that entry is accepted by the drain port, opens a new entry. The store is not lost.
- R10: After reset the buffer is empty: `count` is 0, `empty` and `st_ready` are high, and `drain_valid` is low.
- R11: `count` equals the number of entries in use, and `empty` is high exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Byte address of the stored word |
| st_data | input | DATA_W | Stored word |
| rd_valid | input | 1 | Read lookup request |
| rd_addr | input | ADDR_W | Byte address of the looked-up word |
| rd_hit | output | 1 | Lookup served from the buffer (forward mode) |
| rd_data | output | DATA_W | Forwarded word |
| rd_stall | output | 1 | Read must wait for the buffer to empty (stall mode) |
| drain_valid | output | 1 | Oldest entry offered to memory |
| drain_ready | input | 1 | Memory accepts the offered entry |
| drain_addr | output | ADDR_W | Block base address of the offered entry |
| drain_data | output | WORDS*DATA_W | Words of the offered entry |
| drain_mask | output | WORDS | Valid bit per word of the offered entry |
| count | output | $clog2(DEPTH+1) | Entries in use |
| empty | output | 1 | No entry in use |

## Verification
The bench builds two copies of the block, both with four entries of four 64-bit words and 32-bit addresses. One copy is in forward mode and the other is in stall mode. With only four entries, a short run of stores fills the buffer, so both of these can be tested: refusing a store to a new block, and still accepting a merge into a block that is already held. Running both modes side by side tests the two read policies against the same kind of store traffic. That covers stalling while anything is pending, and forwarding that includes a store made in the same cycle. The tests also cover a store to the oldest block in the very cycle that block leaves, and the order in which entries leave.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // How a read lookup is answered
   typedef enum logic {
      RD_STALL   = 1'b0,  // hold the read until the buffer is empty
      RD_FORWARD = 1'b1   // return buffered data on a word match
   } rd_mode_e;

endpackage

// File: rtl/wbuf_slot.sv
// One buffer entry: block tag, per-word valid bits and word storage.
module wbuf_slot #(
   parameter int TAG_W  = 27,
   parameter int DATA_W = 64,
   parameter int WORDS  = 4,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc,
   input  logic                    merge,
   input  logic                    release_i,
   input  logic [TAG_W-1:0]        wr_tag,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    busy,
   output logic [TAG_W-1:0]        tag,
   output logic [WORDS-1:0]        mask,
   output logic [WORDS*DATA_W-1:0] data
);

   logic [WORDS-1:0][DATA_W-1:0] words_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         mask <= '0;
         tag  <= '0;
      end else begin
         if (release_i) begin
            busy <= 1'b0;
            mask <= '0;
         end
         if (alloc) begin
            busy <= 1'b1;
            tag  <= wr_tag;
            mask <= WORDS'(1) << wr_idx;
         end else if (merge) begin
            mask[wr_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (alloc || merge)
         words_q[wr_idx] <= wr_data;
   end

   assign data = words_q;

   // A new entry may only be opened in a free slot
   assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !busy);

   // A freshly opened entry holds exactly one valid word
   assert_alloc_fresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> (busy && $countones(mask) == 1));

   // A merged word is valid afterwards
   assert_merge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      merge |=> mask[$past(wr_idx)]);

   // Merging only ever targets a live entry that is not leaving
   assert_merge_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
      merge |-> (busy && !release_i));

endmodule

// File: rtl/wbuf_order.sv
// Allocation-order bookkeeping: oldest and next-free pointers plus occupancy.
module wbuf_order #(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         if (push) tail <= tail + PTR_W'(1);
         if (pop)  head <= head + PTR_W'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

   assert_count_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/wbuf_merge.sv
// Merging write buffer between a write-through cache and memory.
module wbuf_merge
   import wbuf_pkg::*;
#(
   parameter int       ADDR_W  = 32,
   parameter int       DATA_W  = 64,
   parameter int       WORDS   = 4,
   parameter int       DEPTH   = 4,
   parameter rd_mode_e RD_MODE = RD_FORWARD
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         st_valid,
   output logic                         st_ready,
   input  logic [ADDR_W-1:0]            st_addr,
   input  logic [DATA_W-1:0]            st_data,
   input  logic                         rd_valid,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic                         rd_hit,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_stall,
   output logic                         drain_valid,
   input  logic                         drain_ready,
   output logic [ADDR_W-1:0]            drain_addr,
   output logic [WORDS*DATA_W-1:0]      drain_data,
   output logic [WORDS-1:0]             drain_mask,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty
);

   localparam int BYTE_W  = $clog2(DATA_W / 8);
   localparam int IDX_W   = $clog2(WORDS);
   localparam int BLK_OFF = BYTE_W + IDX_W;
   localparam int TAG_W   = ADDR_W - BLK_OFF;
   localparam int PTR_W   = $clog2(DEPTH);
   localparam int CNT_W   = $clog2(DEPTH + 1);

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbuf_merge: DEPTH must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("wbuf_merge: WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("wbuf_merge: DATA_W must be a power-of-two number of bits, at least one byte");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("wbuf_merge: ADDR_W too narrow for one block");
   end

   // Address fields
   logic [TAG_W-1:0] st_tag, rd_tag;
   logic [IDX_W-1:0] st_idx, rd_idx;
   assign st_tag = st_addr[ADDR_W-1:BLK_OFF];
   assign st_idx = st_addr[BLK_OFF-1:BYTE_W];
   assign rd_tag = rd_addr[ADDR_W-1:BLK_OFF];
   assign rd_idx = rd_addr[BLK_OFF-1:BYTE_W];

   // Slot state
   logic [DEPTH-1:0]               sl_busy;
   logic [TAG_W-1:0]               sl_tag  [DEPTH];
   logic [WORDS-1:0]               sl_mask [DEPTH];
   logic [WORDS*DATA_W-1:0]        sl_data [DEPTH];
   logic [DEPTH-1:0]               sl_alloc, sl_merge, sl_rel, st_match, is_head;

   logic [PTR_W-1:0] head, tail;
   logic             full;
   logic             st_fire, drain_fire, push, merge_any;

   assign drain_valid = !empty;
   assign drain_fire  = drain_valid && drain_ready;
   assign merge_any   = |st_match;
   assign st_ready    = merge_any || !full;
   assign st_fire     = st_valid && st_ready;
   assign push        = st_fire && !merge_any;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign is_head[i]  = (head == PTR_W'(i));
      // The oldest entry leaving this cycle cannot take a merge
      assign st_match[i] = sl_busy[i] && (sl_tag[i] == st_tag) && !(drain_fire && is_head[i]);
      assign sl_alloc[i] = push && (tail == PTR_W'(i));
      assign sl_merge[i] = st_fire && st_match[i];
      assign sl_rel[i]   = drain_fire && is_head[i];

      wbuf_slot #(
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W),
         .WORDS  (WORDS)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (sl_alloc[i]),
         .merge     (sl_merge[i]),
         .release_i (sl_rel[i]),
         .wr_tag    (st_tag),
         .wr_idx    (st_idx),
         .wr_data   (st_data),
         .busy      (sl_busy[i]),
         .tag       (sl_tag[i]),
         .mask      (sl_mask[i]),
         .data      (sl_data[i])
      );
   end

   wbuf_order #(
      .DEPTH (DEPTH)
   ) u_order (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (drain_fire),
      .head  (head),
      .tail  (tail),
      .cnt   (count),
      .full  (full),
      .empty (empty)
   );

   assign drain_addr = {sl_tag[head], BLK_OFF'(0)};
   assign drain_data = sl_data[head];
   assign drain_mask = sl_mask[head];

   // Read path variant
   if (RD_MODE == RD_FORWARD) begin : g_fwd
      logic unused_fwd;
      assign unused_fwd = ^{st_addr[BYTE_W-1:0], rd_addr[BYTE_W-1:0]};
      assign rd_stall   = 1'b0;

      always_comb begin
         rd_hit  = 1'b0;
         rd_data = '0;
         if (rd_valid) begin
            for (int k = 0; k < DEPTH; k++) begin
               if (sl_busy[k] && sl_tag[k] == rd_tag && sl_mask[k][rd_idx]) begin
                  rd_hit  = 1'b1;
                  rd_data = sl_data[k][int'(rd_idx)*DATA_W +: DATA_W];
               end
            end
            // Same-cycle store wins over the older buffered copy
            if (st_fire && st_addr[ADDR_W-1:BYTE_W] == rd_addr[ADDR_W-1:BYTE_W]) begin
               rd_hit  = 1'b1;
               rd_data = st_data;
            end
         end
      end

      assert_fwd_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hit |-> rd_valid);

      assert_fwd_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hit |-> (!empty || st_fire));
   end else begin : g_stall
      logic unused_stall;
      assign unused_stall = ^{rd_addr, st_addr[BYTE_W-1:0], rd_tag, rd_idx};
      assign rd_hit   = 1'b0;
      assign rd_data  = '0;
      assign rd_stall = rd_valid && (!empty || st_fire);

      assert_stall_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
         rd_stall |-> (count != '0 || st_valid));
   end

   // Every offered entry carries at least one word
   assert_drain_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      drain_valid |-> (drain_mask != '0));

   // An offered entry keeps its address until taken
   assert_drain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_valid && !drain_ready) |=> (drain_valid && drain_addr == $past(drain_addr)));

   // Refusing a store only happens when every entry is in use
   assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |-> (count == CNT_W'(DEPTH)));

   // Occupancy flag agrees with the count
   assert_empty_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !(|sl_busy));

endmodule

// File: tb/wbuf_merge_test.sv
module wbuf_merge_test;
   import wbuf_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic         rst_n;
   // forward-mode copy
   logic         st_valid, st_ready, rd_valid, rd_hit, rd_stall;
   logic         drain_valid, drain_ready, empty;
   logic [31:0]  st_addr, rd_addr, drain_addr;
   logic [63:0]  st_data, rd_data;
   logic [255:0] drain_data;
   logic [3:0]   drain_mask;
   logic [2:0]   count;
   // stall-mode copy
   logic         s_st_valid, s_st_ready, s_rd_valid, s_rd_hit, s_rd_stall;
   logic         s_drain_valid, s_drain_ready, s_empty;
   logic [31:0]  s_st_addr, s_rd_addr, s_drain_addr;
   logic [63:0]  s_st_data, s_rd_data;
   logic [255:0] s_drain_data;
   logic [3:0]   s_drain_mask;
   logic [2:0]   s_count;

   wbuf_merge #(.RD_MODE(RD_FORWARD)) uut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
      .rd_stall(rd_stall),
      .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_addr(drain_addr),
      .drain_data(drain_data), .drain_mask(drain_mask),
      .count(count), .empty(empty));

   wbuf_merge #(.RD_MODE(RD_STALL)) uut_stall (
      .clk(clk), .rst_n(rst_n),
      .st_valid(s_st_valid), .st_ready(s_st_ready), .st_addr(s_st_addr), .st_data(s_st_data),
      .rd_valid(s_rd_valid), .rd_addr(s_rd_addr), .rd_hit(s_rd_hit), .rd_data(s_rd_data),
      .rd_stall(s_rd_stall),
      .drain_valid(s_drain_valid), .drain_ready(s_drain_ready), .drain_addr(s_drain_addr),
      .drain_data(s_drain_data), .drain_mask(s_drain_mask),
      .count(s_count), .empty(s_empty));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // Store vectors: address, data, expected st_ready, expected count afterwards
   typedef struct packed {
      logic [31:0] addr;
      logic [63:0] data;
      logic        ready;
      logic [2:0]  cnt;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h100, 64'h1111_0000_0000_0100, 1'b1, 3'd1},  // R1 new block
      '{32'h108, 64'h1111_0000_0000_0108, 1'b1, 3'd1},  // R2 merge
      '{32'h200, 64'h1111_0000_0000_0200, 1'b1, 3'd2},  // R1
      '{32'h118, 64'h1111_0000_0000_0118, 1'b1, 3'd2},  // R2
      '{32'h300, 64'h1111_0000_0000_0300, 1'b1, 3'd3},  // R1
      '{32'h100, 64'h2222_0000_0000_0100, 1'b1, 3'd3},  // R2 overwrite
      '{32'h400, 64'h1111_0000_0000_0400, 1'b1, 3'd4},  // R1 fills
      '{32'h500, 64'h1111_0000_0000_0500, 1'b0, 3'd4},  // R3 refused
      '{32'h208, 64'h1111_0000_0000_0208, 1'b1, 3'd4}   // R3 merge while full
   };

   localparam logic [63:0] SAME_CYC = 64'h7777_0000_0000_0210;

   task automatic look(input logic [31:0] a, input logic exp_hit,
                       input logic [63:0] exp_d, input string req);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a;
      #1;
      chk(req, {63'd0, rd_hit}, {63'd0, exp_hit});
      if (exp_hit) chk(req, rd_data, exp_d);
      chk({req, " no stall in forward mode"}, {63'd0, rd_stall}, 64'd0);
      rd_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      st_valid = 0; st_addr = 0; st_data = 0; rd_valid = 0; rd_addr = 0; drain_ready = 0;
      s_st_valid = 0; s_st_addr = 0; s_st_data = 0; s_rd_valid = 0; s_rd_addr = 0;
      s_drain_ready = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      chk("R10 count", {61'd0, count}, 64'd0);
      chk("R10 empty", {63'd0, empty}, 64'd1);
      chk("R10 drain_valid", {63'd0, drain_valid}, 64'd0);
      chk("R10 st_ready", {63'd0, st_ready}, 64'd1);

      // Vector walk, drain held off
      for (int i = 0; i < NV; i++) begin
         string req;
         if (i >= 7) req = "R3";
         else if (i == 0 || VECS[i].cnt != VECS[i-1].cnt) req = "R1";
         else req = "R2";
         @(negedge clk);
         st_valid = 1'b1; st_addr = VECS[i].addr; st_data = VECS[i].data;
         #1;
         chk({req, " st_ready"}, {63'd0, st_ready}, {63'd0, VECS[i].ready});
         @(negedge clk);
         st_valid = 1'b0;
         #1;
         chk({req, " count"}, {61'd0, count}, {61'd0, VECS[i].cnt});
         chk("R11 empty flag", {63'd0, empty}, 64'd0);
      end

      // Forward lookups (R6, R2 overwrite, R3 merged word)
      look(32'h108, 1'b1, 64'h1111_0000_0000_0108, "R6 valid word");
      look(32'h100, 1'b1, 64'h2222_0000_0000_0100, "R2 overwritten word");
      look(32'h110, 1'b0, 64'd0, "R6 clear word bit");
      look(32'h600, 1'b0, 64'd0, "R6 absent block");
      look(32'h500, 1'b0, 64'd0, "R3 refused store left nothing");
      look(32'h208, 1'b1, 64'h1111_0000_0000_0208, "R3 merge while full");

      // R7 same-cycle store and lookup
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h210; st_data = SAME_CYC;
      rd_valid = 1'b1; rd_addr = 32'h210;
      #1;
      chk("R7 hit", {63'd0, rd_hit}, 64'd1);
      chk("R7 data", rd_data, SAME_CYC);
      @(negedge clk);
      st_valid = 1'b0; rd_valid = 1'b0;
      #1;
      chk("R7 count", {61'd0, count}, 64'd4);

      // R4 offer held while not ready
      chk("R4 drain_valid", {63'd0, drain_valid}, 64'd1);
      chk("R4 drain_addr", {32'd0, drain_addr}, 64'h100);
      @(negedge clk);
      #1;
      chk("R4 addr held", {32'd0, drain_addr}, 64'h100);
      chk("R4 mask", {60'd0, drain_mask}, 64'b1011);
      chk("R4 word0", drain_data[63:0], 64'h2222_0000_0000_0100);
      chk("R4 word1", drain_data[127:64], 64'h1111_0000_0000_0108);
      chk("R4 word3", drain_data[255:192], 64'h1111_0000_0000_0118);

      // R5 order of leaving
      drain_ready = 1'b1;
      @(negedge clk);
      #1;
      chk("R5 second addr", {32'd0, drain_addr}, 64'h200);
      chk("R5 second mask", {60'd0, drain_mask}, 64'b0111);
      chk("R7 stored word", drain_data[191:128], SAME_CYC);
      chk("R11 count after drain", {61'd0, count}, 64'd3);
      @(negedge clk);
      #1;
      chk("R5 third addr", {32'd0, drain_addr}, 64'h300);
      chk("R5 third mask", {60'd0, drain_mask}, 64'b0001);
      @(negedge clk);
      #1;
      chk("R5 fourth addr", {32'd0, drain_addr}, 64'h400);
      @(negedge clk);
      drain_ready = 1'b0;
      #1;
      chk("R11 empty", {63'd0, empty}, 64'd1);
      chk("R11 count zero", {61'd0, count}, 64'd0);
      chk("R4 drain_valid low", {63'd0, drain_valid}, 64'd0);
      look(32'h108, 1'b0, 64'd0, "R6 drained word gone");

      // R9 store to the leaving block
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h500; st_data = 64'hAAAA_0000_0000_0500;
      @(negedge clk);
      st_data = 64'hBBBB_0000_0000_0508; st_addr = 32'h508;
      drain_ready = 1'b1;
      #1;
      chk("R9 st_ready", {63'd0, st_ready}, 64'd1);
      @(negedge clk);
      st_valid = 1'b0; drain_ready = 1'b0;
      #1;
      chk("R9 count", {61'd0, count}, 64'd1);
      chk("R9 addr", {32'd0, drain_addr}, 64'h500);
      chk("R9 mask", {60'd0, drain_mask}, 64'b0010);
      chk("R9 word1", drain_data[127:64], 64'hBBBB_0000_0000_0508);

      // R8 stall mode
      @(negedge clk);
      s_rd_valid = 1'b1; s_rd_addr = 32'h100;
      #1;
      chk("R8 empty no stall", {63'd0, s_rd_stall}, 64'd0);
      chk("R8 no hit", {63'd0, s_rd_hit}, 64'd0);
      s_st_valid = 1'b1; s_st_addr = 32'h100; s_st_data = 64'h5;
      #1;
      chk("R8 same-cycle store stalls", {63'd0, s_rd_stall}, 64'd1);
      @(negedge clk);
      s_st_valid = 1'b0;
      #1;
      chk("R8 pending stalls", {63'd0, s_rd_stall}, 64'd1);
      chk("R8 never hits", {63'd0, s_rd_hit}, 64'd0);
      s_drain_ready = 1'b1;
      @(negedge clk);
      s_drain_ready = 1'b0;
      #1;
      chk("R8 released when empty", {63'd0, s_rd_stall}, 64'd0);
      s_rd_valid = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule